// File: doc/BRIEF.md
# Banked ROM Controller with Nibble-Wide Work RAM

This block sits between an 8-bit processor with a 16-bit address space and a cartridge ROM. The lower 16 KiB of the processor's code space always shows ROM bank 0. The upper 16 KiB is a window onto one of up to 16 ROM banks, picked by a 4-bit bank register. The block turns each processor address into a physical ROM address. It returns either the ROM byte or the content of a small internal work RAM.

The work RAM holds 512 entries of 4 bits each and occupies 0xA000-0xA1FF. Software must first unlock it by writing a key to the low control region. Writes to the two control regions are told apart by address bit 8: with the bit clear, a write in the first 8 KiB updates the RAM unlock. With the bit set, a write in the second 8 KiB updates the bank register. All writes take effect at the rising clock edge. Reads are combinational from the address, and the ROM answers through `rom_rdata`.

Top module: `nibble_bank_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the bank register reads as 1 and the work RAM is locked.
- R2: A write in 0x0000-0x1FFF with address bit 8 at 0 unlocks the RAM when data bits 3:0 equal 0xA. Any other value in those bits locks it.
- R3: A write in 0x2000-0x3FFF with address bit 8 at 1 loads the bank from data bits 3:0. A value of 0 is stored as 1, so the bank is never 0.
- R4: A write in 0x0000-0x1FFF with address bit 8 at 1 leaves the lock unchanged. A write in 0x2000-0x3FFF with address bit 8 at 0 leaves the bank unchanged.
- R5: Writes in 0x4000-0x7FFF, and writes to addresses outside the control regions and the RAM window, change no state.
- R6: For a read below 0x4000, `rom_addr` equals the 14 low address bits with bank bits 17:14 at 0. For a read in 0x4000-0x7FFF, `rom_addr` is bank × 0x4000 plus address bits 13:0. For any read below 0x8000, `rd_data` equals `rom_rdata`.
- R7: While unlocked, a write in 0xA000-0xA1FF stores data bits 3:0 at entry (address − 0xA000). A read there returns that nibble in bits 3:0 with bits 7:4 at 0.
- R8: While locked, reads in 0xA000-0xA1FF return 0x00 and writes there are dropped, so earlier contents survive.
- R9: Reads from any address at or above 0x8000 outside 0xA000-0xA1FF return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_wr | input | 1 | Write strobe, sampled at the rising edge |
| rom_addr | output | 18 | Physical ROM byte address |
| rom_rdata | input | 8 | Byte returned by the ROM for `rom_addr` |
| rd_data | output | 8 | Read data for the processor |

## Verification
The hardest case to reach is a dropped RAM write while the RAM is locked. It can only be seen after the RAM is unlocked again and the old nibble is read back. The stimulus therefore fills the whole RAM while unlocked, locks it, writes over an entry, and unlocks it with a key whose upper data bits are non-zero. It also runs through control-region addresses with bit 8 on the wrong side, so that ignored writes show up as an unchanged bank in `rom_addr` or unchanged RAM access. A long mixed random phase follows, and a behavioural model is compared on every clock.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  localparam int CPU_AW  = 16;
  localparam int CPU_DW  = 8;
  localparam int NIB_W   = 4;
  localparam int BANK_W  = 4;
  localparam int WIN_AW  = 14;
  localparam int ROM_AW  = BANK_W + WIN_AW;
  localparam logic [NIB_W-1:0] UNLOCK_KEY = 4'hA;

  typedef enum logic [2:0] {
    WR_LOCK, WR_BANK, WR_ROMWIN, WR_NRAM, WR_NONE
  } wr_region_e;

  // which write region an address falls in (bit 8 handled by the decoder)
  function automatic wr_region_e classify(input logic [CPU_AW-1:0] a,
                                          input logic nram_hit);
    if (a[15:13] == 3'b000)      return WR_LOCK;
    else if (a[15:13] == 3'b001) return WR_BANK;
    else if (a[15:14] == 2'b01)  return WR_ROMWIN;
    else if (nram_hit)           return WR_NRAM;
    else                         return WR_NONE;
  endfunction

  // a zero bank request is promoted to bank 1
  function automatic logic [BANK_W-1:0] fold_bank(input logic [BANK_W-1:0] v);
    return (v == '0) ? BANK_W'(1) : v;
  endfunction

  // physical ROM byte address for a processor address
  function automatic logic [ROM_AW-1:0] rom_phys(input logic [CPU_AW-1:0] a,
                                                 input logic [BANK_W-1:0] bank);
    logic [BANK_W-1:0] b;
    b = a[WIN_AW] ? bank : '0;
    return {b, a[WIN_AW-1:0]};
  endfunction
endpackage

// File: rtl/nbc_decode.sv
module nbc_decode
  import nbc_pkg::*;
#(
  parameter int NRAM_DEPTH = 512,
  parameter logic [CPU_AW-1:0] NRAM_BASE = 16'hA000,
  localparam int IDX_W = $clog2(NRAM_DEPTH)
) (
  input  logic [CPU_AW-1:0] addr,
  input  logic              wr,
  input  logic              ram_open,
  output logic              nram_hit,
  output logic              rom_hit,
  output logic              lock_wr_evt,
  output logic              bank_wr_evt,
  output logic              nram_wr_evt
);
  wr_region_e region;

  assign nram_hit = (addr[CPU_AW-1:IDX_W] == NRAM_BASE[CPU_AW-1:IDX_W]);
  assign rom_hit  = ~addr[CPU_AW-1];
  assign region   = classify(addr, nram_hit);

  assign lock_wr_evt = wr && (region == WR_LOCK) && !addr[8];
  assign bank_wr_evt = wr && (region == WR_BANK) &&  addr[8];
  assign nram_wr_evt = wr && (region == WR_NRAM) && ram_open;
endmodule

// File: rtl/nbc_ctrl_regs.sv
module nbc_ctrl_regs
  import nbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_wr_evt,
  input  logic              bank_wr_evt,
  input  logic [NIB_W-1:0]  wnib,
  output logic              ram_open,
  output logic [BANK_W-1:0] bank
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_open <= 1'b0;
      bank     <= BANK_W'(1);
    end else begin
      if (lock_wr_evt) ram_open <= (wnib == UNLOCK_KEY);
      if (bank_wr_evt) bank     <= fold_bank(wnib[BANK_W-1:0]);
    end
  end
endmodule

// File: rtl/nbc_nram.sv
module nbc_nram
  import nbc_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [NIB_W-1:0] wnib,
  output logic [NIB_W-1:0] rnib
);
  logic [NIB_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wnib;
  end

  assign rnib = cells[idx];
endmodule

// File: rtl/nibble_bank_ctrl.sv
module nibble_bank_ctrl
  import nbc_pkg::*;
#(
  parameter int NRAM_DEPTH = 512,
  parameter logic [CPU_AW-1:0] NRAM_BASE = 16'hA000,
  localparam int IDX_W = $clog2(NRAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [CPU_DW-1:0] cpu_wdata,
  input  logic              cpu_wr,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [CPU_DW-1:0] rom_rdata,
  output logic [CPU_DW-1:0] rd_data
);
  logic              ram_open;
  logic [BANK_W-1:0] bank;
  logic              nram_hit, rom_hit;
  logic              lock_wr_evt, bank_wr_evt, nram_wr_evt;
  logic [NIB_W-1:0]  rnib;
  logic [NIB_W-1:0]  wnib;

  assign wnib = cpu_wdata[NIB_W-1:0];

  nbc_decode #(.NRAM_DEPTH(NRAM_DEPTH), .NRAM_BASE(NRAM_BASE)) u_dec (
    .addr(cpu_addr), .wr(cpu_wr), .ram_open(ram_open),
    .nram_hit(nram_hit), .rom_hit(rom_hit),
    .lock_wr_evt(lock_wr_evt), .bank_wr_evt(bank_wr_evt),
    .nram_wr_evt(nram_wr_evt)
  );

  nbc_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .lock_wr_evt(lock_wr_evt), .bank_wr_evt(bank_wr_evt),
    .wnib(wnib), .ram_open(ram_open), .bank(bank)
  );

  nbc_nram #(.DEPTH(NRAM_DEPTH)) u_ram (
    .clk(clk), .we(nram_wr_evt), .idx(cpu_addr[IDX_W-1:0]),
    .wnib(wnib), .rnib(rnib)
  );

  assign rom_addr = rom_phys(cpu_addr, bank);

  always_comb begin
    if (rom_hit)                   rd_data = rom_rdata;
    else if (nram_hit && ram_open) rd_data = {{(CPU_DW-NIB_W){1'b0}}, rnib};
    else                           rd_data = '0;
  end
endmodule

// File: rtl/nbc_checker.sv
module nbc_checker
  import nbc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic [CPU_DW-1:0] cpu_wdata,
  input logic              cpu_wr,
  input logic [ROM_AW-1:0] rom_addr,
  input logic [CPU_DW-1:0] rd_data,
  input logic              ram_open,
  input logic [BANK_W-1:0] bank,
  input logic              lock_wr_evt,
  input logic              bank_wr_evt,
  input logic              nram_wr_evt,
  input logic              nram_hit
);
  p_bank_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bank != '0);

  p_bank_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr_evt |=> bank == (($past(cpu_wdata[3:0]) == 4'h0) ? 4'h1 : $past(cpu_wdata[3:0])));

  p_lock_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr_evt |=> ram_open == ($past(cpu_wdata[3:0]) == 4'hA));

  p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_wr_evt |=> $stable(ram_open));

  p_bank_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_wr_evt |=> $stable(bank));

  p_misbit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_addr[8]) |-> !lock_wr_evt);

  p_nram_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nram_hit |-> rd_data[7:4] == 4'h0);

  p_locked_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nram_hit && !ram_open) |-> rd_data == '0);

  p_locked_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nram_wr_evt |-> ram_open);

  p_low_bank0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b00) |-> rom_addr[ROM_AW-1:WIN_AW] == '0);
endmodule

bind nibble_bank_ctrl nbc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_wr(cpu_wr), .rom_addr(rom_addr), .rd_data(rd_data),
  .ram_open(ram_open), .bank(bank), .lock_wr_evt(lock_wr_evt),
  .bank_wr_evt(bank_wr_evt), .nram_wr_evt(nram_wr_evt), .nram_hit(nram_hit)
);

// File: tb/nibble_bank_ctrl_test.sv
module nibble_bank_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic [17:0] rom_addr;
  logic [7:0]  rom_rdata;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;

  // reference state
  int m_bank = 1;
  bit m_open = 0;
  int m_ram [512];

  always #10 clk = ~clk;

  // ROM model: byte content is a hash of the byte address
  function automatic logic [7:0] rom_byte(input int a);
    return 8'((a * 37 + (a >> 9)) & 255);
  endfunction
  assign rom_rdata = rom_byte(int'(rom_addr));

  nibble_bank_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .rom_addr(rom_addr), .rom_rdata(rom_rdata), .rd_data(rd_data)
  );

  function automatic int exp_rom(input int a);
    if (a < 16384) return a;
    return m_bank * 16384 + (a - 16384);
  endfunction

  function automatic int exp_data(input int a);
    if (a < 32768) return int'(rom_byte(exp_rom(a)));
    if (a >= 40960 && a < 41472) return m_open ? m_ram[a - 40960] : 0;
    return 0;
  endfunction

  task automatic compare(input string req);
    int a;
    a = int'(cpu_addr);
    checks++;
    if (a < 32768 && int'(rom_addr) != exp_rom(a)) begin
      errors++;
      $display("FAIL %s addr=%h rom_addr actual=%h expected=%h", req, a, rom_addr, exp_rom(a));
    end else if (int'(rd_data) != exp_data(a)) begin
      errors++;
      $display("FAIL %s addr=%h rd_data actual=%h expected=%h", req, a, rd_data, exp_data(a));
    end
  endtask

  // one bus cycle: drive, compare outputs, clock, update model
  task automatic cyc(input int a, input int d, input bit w, input string req);
    cpu_addr = 16'(a); cpu_wdata = 8'(d); cpu_wr = w;
    #2;
    compare(req);
    @(posedge clk);
    if (w) begin
      if (a < 8192) begin
        if (((a >> 8) & 1) == 0) m_open = ((d & 15) == 10);
      end else if (a < 16384) begin
        if (((a >> 8) & 1) == 1) m_bank = ((d & 15) == 0) ? 1 : (d & 15);
      end else if (a >= 40960 && a < 41472 && m_open) begin
        m_ram[a - 40960] = d & 15;
      end
    end
    @(negedge clk);
  endtask

  task automatic rd(input int a, input string req);
    cyc(a, 0, 0, req);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) m_ram[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // r1_ reset state seen while reset is still held
    cpu_addr = 16'h4000; #2; compare("R1");
    cpu_addr = 16'hA010; #2; compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    rd(16'h4ABC, "R1");
    rd(16'hA000, "R1");

    // R2 unlock, then fill the RAM (R7)
    cyc(16'h0000, 8'h0A, 1, "R2");
    for (int i = 0; i < 512; i++) cyc(16'hA000 + i, (i * 7 + 3) | 8'hE0, 1, "R7");
    rd(16'hA005, "R7");
    rd(16'hA1FF, "R7");
    cyc(16'hA1FF, 8'hC7, 1, "R7");
    rd(16'hA1FF, "R7");

    // R8 locked: reads 0, writes dropped
    cyc(16'h1E00, 8'h3B, 1, "R2");
    rd(16'hA005, "R8");
    cyc(16'hA005, 8'hFF, 1, "R8");
    cyc(16'h1E3A, 8'h5A, 1, "R2");
    rd(16'hA005, "R8");

    // R4 wrong bit 8 ignored
    cyc(16'h0100, 8'h00, 1, "R4");
    rd(16'hA005, "R4");
    cyc(16'h2000, 8'h03, 1, "R4");
    rd(16'h4000, "R4");

    // R3 bank loads and zero fold
    cyc(16'h2100, 8'h03, 1, "R3");
    rd(16'h7FFF, "R3");
    cyc(16'h3F00, 8'hF0, 1, "R3");
    rd(16'h5555, "R3");
    cyc(16'h2100, 8'h0F, 1, "R3");
    rd(16'h4123, "R3");

    // R5 writes elsewhere change nothing
    cyc(16'h5100, 8'h00, 1, "R5");
    cyc(16'h6000, 8'h01, 1, "R5");
    cyc(16'h8000, 8'h0A, 1, "R5");
    cyc(16'hC000, 8'h0A, 1, "R5");
    rd(16'h4123, "R5");
    rd(16'hA005, "R5");

    // R6 fixed window, R9 other reads
    rd(16'h0123, "R6");
    rd(16'h3FFF, "R6");
    rd(16'hA200, "R9");
    rd(16'hFFFF, "R9");
    rd(16'h9FFF, "R9");

    // mixed random phase
    for (int k = 0; k < 3000; k++) begin
      int sel, a, d;
      sel = $urandom_range(0, 5);
      d = $urandom_range(0, 255);
      case (sel)
        0: a = $urandom_range(0, 8191);
        1: a = $urandom_range(8192, 16383);
        2: a = $urandom_range(16384, 32767);
        3: a = $urandom_range(40960, 41471);
        4: a = $urandom_range(40960, 41471);
        default: a = $urandom_range(32768, 65535);
      endcase
      cyc(a, d, $urandom_range(0, 1) == 1, "R6");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule